// File: doc/BRIEF.md
# Pad Interrupt Router with Trigger Conditioning

This block watches a wide bank of input pads and steers any one of them onto each of eight interrupt lines. Every line is configured on its own: which pad it listens to, whether it reports a level or an edge, which sense counts as active, and how long a new value has to persist before it is believed. Four 32-bit configuration words, reached through a plain write-enable/word-index bus with a combinational read port, hold all of this.

Each line conditions its pad the same way. The selected pad is inverted when the low sense is chosen, passed through a two-stage synchroniser, debounced by a per-line persistence filter, and then either forwarded as a level or reduced to a one-clock pulse on its rising transition. The interrupt controller downstream therefore only ever sees active-high levels or rising pulses, whatever the pad does. A line whose selector points past the last implemented pad stays inactive.

Top module: `pad_irq_router`

## Requirements
- R1: After synchronous reset every configuration word reads zero and all eight interrupt lines are low.
- R2: Word index 0 (byte offset 0x0) holds the trigger words, index 1 (0x4) the selectors of lines 0..3, index 2 (0x8) the selectors of lines 4..7, and index 3 (0xC) the filter lengths. A write is visible on the read port from the next clock cycle. In word 0, bits 15..8 and 31..24 always read zero.
- R3: Line x takes its 8-bit pad number from bits (x mod 4)*8 upward of word 1 (x < 4) or word 2 (x >= 4).
- R4: In level mode with high sense and filter length 0, a line follows its pad. A pad change driven before a clock edge shows on the line after the fourth edge.
- R5: Bit 16+x of word 0 selects the low sense for line x. In level mode the line is then high while the pad is low and low while it is high.
- R6: Bit x of word 0 set puts line x in edge mode. With high sense, each rising pad transition gives exactly one pulse, one clock wide, after the fourth edge. A falling transition gives none.
- R7: In edge mode with low sense, a falling pad transition gives one pulse and a rising one gives none.
- R8: Line x takes a 4-bit filter length N from bits x*4 upward of word 3. For N > 0, a new synchronised value must persist for N consecutive cycles before it is passed on, so a level line responds after 3+N edges. A shorter excursion is dropped. N = 0 behaves as N = 1.
- R9: A selector equal to or above the number of implemented pads holds the line inactive under either sense. The highest implemented pad is still routed.
- R10: Lines are independent. Two lines on the same pad with different modes each behave according to their own setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pads | input | NUM_PADS | Asynchronous pad inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration word index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the indexed word |
| irq_out | output | 8 | Conditioned interrupt lines, one per channel |

## Verification
Four behaviours are checked on every cycle. Reset clears the outputs and the read port. Word 0 never returns its spare bits. A selector word written in one cycle reads back unchanged in the next. An edge-mode line never stays high for two consecutive cycles. Properties that depend on the pad history cannot be expressed that way, so only the directed scenarios show them: pipeline latency, inversion under low sense, which transition counts under each sense, rejection of glitches by the filter, inactivity of out-of-range selectors, and independence of lines that share a pad.

// File: rtl/pad_irq_pkg.sv
package pad_irq_pkg;

    localparam int CH_COUNT   = 8;
    localparam int SEL_W      = 8;
    localparam int FLT_W      = 4;
    localparam int WORD_W     = 32;
    localparam int SEL_PER_WD = WORD_W / SEL_W;
    localparam int SENSE_BASE = 16;

    typedef enum logic [1:0] {
        WD_TRIGGER = 2'd0,
        WD_SEL_LO  = 2'd1,
        WD_SEL_HI  = 2'd2,
        WD_FILTER  = 2'd3
    } cfg_word_e;

    typedef struct packed {
        logic             edge_mode;
        logic             low_sense;
        logic [SEL_W-1:0] pad_sel;
        logic [FLT_W-1:0] flt_len;
    } ch_cfg_t;

    // Pack the per-line trigger bits into their word image.
    function automatic logic [WORD_W-1:0] trigger_word(
        input logic [CH_COUNT-1:0] edge_bits,
        input logic [CH_COUNT-1:0] sense_bits
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[CH_COUNT-1:0] = edge_bits;
        w[SENSE_BASE +: CH_COUNT] = sense_bits;
        return w;
    endfunction

endpackage

// File: rtl/pad_irq_regs.sv
module pad_irq_regs
    import pad_irq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [1:0]                 word_idx,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          rdata,
    output ch_cfg_t [CH_COUNT-1:0]     cfg
);

    logic [CH_COUNT-1:0] edge_q;
    logic [CH_COUNT-1:0] sense_q;
    logic [WORD_W-1:0]   sel_lo_q;
    logic [WORD_W-1:0]   sel_hi_q;
    logic [WORD_W-1:0]   filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q   <= '0;
            sense_q  <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            filt_q   <= '0;
        end else if (we) begin
            case (cfg_word_e'(word_idx))
                WD_TRIGGER: begin
                    edge_q  <= wdata[CH_COUNT-1:0];
                    sense_q <= wdata[SENSE_BASE +: CH_COUNT];
                end
                WD_SEL_LO: sel_lo_q <= wdata;
                WD_SEL_HI: sel_hi_q <= wdata;
                default:   filt_q   <= wdata;
            endcase
        end
    end

    always_comb begin
        case (cfg_word_e'(word_idx))
            WD_TRIGGER: rdata = trigger_word(edge_q, sense_q);
            WD_SEL_LO:  rdata = sel_lo_q;
            WD_SEL_HI:  rdata = sel_hi_q;
            default:    rdata = filt_q;
        endcase
    end

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_cfg
        assign cfg[g].edge_mode = edge_q[g];
        assign cfg[g].low_sense = sense_q[g];
        assign cfg[g].flt_len   = filt_q[g*FLT_W +: FLT_W];
        if (g < SEL_PER_WD) begin : g_lo
            assign cfg[g].pad_sel = sel_lo_q[(g % SEL_PER_WD)*SEL_W +: SEL_W];
        end else begin : g_hi
            assign cfg[g].pad_sel = sel_hi_q[(g % SEL_PER_WD)*SEL_W +: SEL_W];
        end
    end

endmodule

// File: rtl/pad_irq_filter.sv
module pad_irq_filter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [LEN_W-1:0] len,
    output logic             dout
);

    logic             sync_a;
    logic             sync_b;
    logic             stable_q;
    logic [LEN_W-1:0] hold_cnt;
    logic             accept;

    // Length 0 and 1 both accept a change seen for a single cycle.
    assign accept = (len == '0) || (hold_cnt == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            stable_q <= 1'b0;
            hold_cnt <= '0;
        end else begin
            sync_a <= din;
            sync_b <= sync_a;
            if (sync_b == stable_q) begin
                hold_cnt <= '0;
            end else if (accept) begin
                stable_q <= sync_b;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + LEN_W'(1);
            end
        end
    end

    assign dout = stable_q;

endmodule

// File: rtl/pad_irq_channel.sv
module pad_irq_channel
    import pad_irq_pkg::*;
#(
    parameter int NUM_PADS = 134
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pads,
    input  ch_cfg_t             cfg,
    output logic                irq
);

    logic pad_hit;
    logic pad_val;
    logic cond_in;
    logic filt_val;
    logic filt_prev;
    logic irq_q;

    always_comb begin
        pad_hit = 1'b0;
        pad_val = 1'b0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (cfg.pad_sel == SEL_W'(p)) begin
                pad_hit = 1'b1;
                pad_val = pads[p];
            end
        end
    end

    // Out-of-range selectors give the inactive level after inversion.
    assign cond_in = pad_hit & (pad_val ^ cfg.low_sense);

    pad_irq_filter #(
        .LEN_W (FLT_W)
    ) u_filter (
        .clk  (clk),
        .rst  (rst),
        .din  (cond_in),
        .len  (cfg.flt_len),
        .dout (filt_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_prev <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            filt_prev <= filt_val;
            irq_q     <= cfg.edge_mode ? (filt_val & ~filt_prev) : filt_val;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
    import pad_irq_pkg::*;
#(
    parameter int NUM_PADS = 134
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pads,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [7:0]          irq_out
);

    ch_cfg_t [CH_COUNT-1:0] cfg_vec;
    logic    [CH_COUNT-1:0] edge_vec;

    pad_irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .word_idx (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg      (cfg_vec)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        assign edge_vec[g] = cfg_vec[g].edge_mode;

        pad_irq_channel #(
            .NUM_PADS (NUM_PADS)
        ) u_ch (
            .clk  (clk),
            .rst  (rst),
            .pads (pads),
            .cfg  (cfg_vec[g]),
            .irq  (irq_out[g])
        );
    end

endmodule

// File: rtl/pad_irq_router_chk.sv
module pad_irq_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [7:0]  irq_out,
    input logic [7:0]  edge_vec
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (irq_out == 8'h00 && cfg_rdata == 32'h0)); // R1

    AST_TRIGGER_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 2'd0) |-> (cfg_rdata[15:8] == 8'h00 && cfg_rdata[31:24] == 8'h00)); // R2

    AST_SELECT_READBACK: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd1) |=> (cfg_addr != 2'd1 || cfg_rdata == $past(cfg_wdata))); // R2

    for (genvar g = 0; g < 8; g++) begin : g_pulse
        AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            (edge_vec[g] && irq_out[g]) |=> (!edge_vec[g] || !irq_out[g])); // R6
    end

endmodule

bind pad_irq_router pad_irq_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_out   (irq_out),
    .edge_vec  (edge_vec)
);

// File: tb/pad_irq_router_test.sv
`timescale 1ns/1ps
module pad_irq_router_test;

    localparam int NP = 134;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pads = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [7:0]    irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pad_irq_router #(.NUM_PADS(NP)) uut (
        .clk       (clk),
        .rst       (rst),
        .pads      (pads),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = idx;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Edges until irq_out[ch] equals val; 0 if not within max.
    task automatic latency(input int ch, input logic val, input int max, output int n);
        n = 0;
        for (int i = 1; i <= max; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_out[ch] === val) begin n = i; break; end
        end
    endtask

    task automatic pulses(input int ch, input int win, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= win; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_out[ch]) begin cnt++; if (first == 0) first = i; end
        end
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", {24'h0, irq_out}, 32'h0);
        for (int i = 0; i < 4; i++) rd_chk("R1 word reset", 2'(i), 32'h0);
    endtask

    task automatic t_regs;
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R2 trigger spare bits", 2'd0, 32'h00FF_00FF);
        wr(2'd1, 32'h1234_5678);
        rd_chk("R2 select lo readback", 2'd1, 32'h1234_5678);
        wr(2'd3, 32'hA5C3_0F96);
        rd_chk("R2 filter readback", 2'd3, 32'hA5C3_0F96);
        wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd3, 32'h0);
        settle(10);
    endtask

    task automatic t_level;
        int n;
        pads = '0;
        wr(2'd2, 32'd100 << 8);   // R3: line 5 -> pad 100 in bits 15:8 of word 2
        settle(8);
        chk("R4 idle level", {24'h0, irq_out}, 32'h0);
        pads[100] = 1'b1;
        latency(5, 1'b1, 10, n);
        chk("R4 rise latency", n, 4);
        chk("R3 only line 5", {24'h0, irq_out}, 32'h20);
        pads[100] = 1'b0;
        latency(5, 1'b0, 10, n);
        chk("R8 bypass fall latency", n, 4);
    endtask

    task automatic t_lowpol;
        wr(2'd0, 32'h1 << 21);
        settle(8);
        chk("R5 low sense pad low", irq_out[5], 1'b1);
        pads[100] = 1'b1;
        settle(8);
        chk("R5 low sense pad high", irq_out[5], 1'b0);
        pads[100] = 1'b0;
    endtask

    task automatic t_rise;
        int c, f;
        pads = '0;
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd7 << 16);    // line 2 -> pad 7
        wr(2'd0, 32'h1 << 2);
        settle(10);
        pads[7] = 1'b1;
        pulses(2, 10, c, f);
        chk("R6 rising pulse count", c, 1);
        chk("R6 rising pulse timing", f, 4);
        pads[7] = 1'b0;
        pulses(2, 10, c, f);
        chk("R6 no pulse on fall", c, 0);
    endtask

    task automatic t_fall;
        int c, f;
        wr(2'd0, (32'h1 << 2) | (32'h1 << 18));
        settle(10);
        pads[7] = 1'b1;
        pulses(2, 10, c, f);
        chk("R7 no pulse on rise", c, 0);
        pads[7] = 1'b0;
        pulses(2, 10, c, f);
        chk("R7 falling pulse count", c, 1);
        chk("R7 falling pulse timing", f, 4);
    endtask

    task automatic t_filter;
        int n, c, f;
        pads = '0;
        wr(2'd1, 32'h0);
        wr(2'd2, 32'd100 << 8);
        wr(2'd0, 32'h0);
        wr(2'd3, 32'd3 << 20);    // line 5 length 3
        settle(12);
        pads[100] = 1'b1;
        latency(5, 1'b1, 12, n);
        chk("R8 filtered rise latency", n, 6);
        settle(4);
        @(negedge clk) pads[100] = 1'b0;
        @(negedge clk);
        @(negedge clk) pads[100] = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!irq_out[5]) c++;
        end
        chk("R8 glitch dropped", c, 0);
        pads[100] = 1'b0;
        latency(5, 1'b0, 12, n);
        chk("R8 filtered fall latency", n, 6);
        wr(2'd3, 32'h0);
    endtask

    task automatic t_range;
        wr(2'd2, {8'd134, 8'd200, 8'd100, 8'd133});
        wr(2'd0, (32'h1 << 22) | (32'h1 << 23));
        pads = '1;
        settle(10);
        chk("R9 out of range inactive, last pad routed", {28'h0, irq_out[7:4]}, 32'h3);
        pads = '0;
        settle(10);
        chk("R9 out of range inactive under low sense", {28'h0, irq_out[7:4]}, 32'h0);
    endtask

    task automatic t_indep;
        pads = '0;
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0000_0909);  // lines 0 and 1 -> pad 9
        wr(2'd0, 32'h1 << 1);
        settle(10);
        pads[9] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 level and edge together", {24'h0, irq_out}, 32'h03);
        @(negedge clk);
        chk("R10 level holds, edge ends", {24'h0, irq_out}, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_level();
        t_lowpol();
        t_rise();
        t_fall();
        t_filter();
        t_range();
        t_indep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule